// File: doc/BRIEF.md
# MSI Write Window Interceptor

This block sits on a memory-mapped request path and watches every upstream request. A request whose address falls in the interrupt window from 0xFEE00000 to 0xFEEFFFFF is claimed by the block. Every other request goes on to the downstream port unchanged.

A claimed 4-byte write becomes an interrupt message. Its address is the window base plus the offset of the write inside the window, zero-extended to 64 bits. Its data is the 32-bit write value. The message goes to an external remap translator over a valid/ready request channel, and the translator answers on a response channel. A fault from the translator drops the interrupt, and the upstream write completes with an error. On success the block issues a downstream 4-byte write of the translated data to the translated address. The upstream write then completes OK. The outcome of that downstream write is never examined.

A claimed read completes OK with zero data and has no effect. A claimed access of any size other than 4 bytes completes with an error and is never sent to the translator. The block keeps one interrupt write in flight. While it is busy, it holds upstream ready low and forwards no other traffic. Bus data is little-endian: byte lane 0 (bits 7:0) carries the lowest-addressed byte, so the 32-bit value is used as it stands.

Top module: `msi_window_intercept`

## Requirements
- R1: The block claims a request when its address lies between 0xFEE00000 and 0xFEEFFFFF inclusive. When idle, it forwards any other request to the downstream port in the same cycle: valid, write, size, data and the address zero-extended to 64 bits. up_ready_o then equals dn_ready_i.
- R2: A claimed read with size code 2 (size codes are log2 of the byte count, so 2 means 4 bytes) gets a response in the cycle after acceptance. The response has err 0 and rdata 0, and no translator request or downstream write follows.
- R3: A claimed access with a size code other than 2, read or write, gets an error response in the cycle after acceptance and raises no translator request.
- R4: In the cycle after a claimed 4-byte write is accepted, the translator request rises. It carries address {32'h0, 0xFEE00000 + offset} and the write value as data, and it stays asserted and stable until xl_req_ready_i is high.
- R5: If the translator response has err set, the response in the following cycle has err 1 and no downstream write is issued.
- R6: If the translator response has err clear, a downstream write with size code 2 follows in the next cycle, carrying the translated address and data. It is held until dn_ready_i is high, and an OK response follows in the cycle after that handshake.
- R7: From the cycle after a window write is captured until its completion is signalled, up_ready_o is low and no upstream request is forwarded downstream.
- R8: During and right after reset, no response, translator request or downstream request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_valid_i | input | 1 | Upstream request valid |
| up_ready_o | output | 1 | Upstream request ready |
| up_write_i | input | 1 | 1 = write, 0 = read |
| up_addr_i | input | 32 | Upstream address |
| up_size_i | input | 3 | Access size code, log2 of the byte count |
| up_wdata_i | input | 32 | Write data, little-endian |
| up_rsp_valid_o | output | 1 | Response pulse for claimed accesses |
| up_rsp_err_o | output | 1 | Response error flag |
| up_rsp_rdata_o | output | 32 | Read data, always zero |
| xl_req_valid_o | output | 1 | Translator request valid |
| xl_req_ready_i | input | 1 | Translator request ready |
| xl_req_addr_o | output | 64 | Message address |
| xl_req_data_o | output | 32 | Message data |
| xl_rsp_valid_i | input | 1 | Translator response valid |
| xl_rsp_err_i | input | 1 | Translation fault |
| xl_rsp_addr_i | input | 64 | Translated address |
| xl_rsp_data_i | input | 32 | Translated data |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream ready |
| dn_write_o | output | 1 | Downstream write flag |
| dn_addr_o | output | 64 | Downstream address |
| dn_size_o | output | 3 | Downstream size code |
| dn_wdata_o | output | 32 | Downstream write data |

## Verification
The assertions check on every cycle that the translator request and the block's own downstream write stay stable while they stall. They also check the response that follows a claimed read, a bad-size access, a fault and a successful downstream handshake, and that ready drops once a write is captured. Only the bench scenarios show the window edges: the first and last claimed addresses, and the addresses just outside on either side. The bench also covers the exact translated address and data, pass-through forwarding with ready coupling, and that a request offered during a busy interval is blocked rather than forwarded.

// File: rtl/msi_win_pkg.sv
package msi_win_pkg;
  localparam int MSG_ADDR_W = 64;
  localparam int MSG_DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XREQ  = 2'd1,
    ST_XWAIT = 2'd2,
    ST_DNWR  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [MSG_ADDR_W-1:0] addr;
    logic [MSG_DATA_W-1:0] data;
  } msi_msg_t;
endpackage

// File: rtl/msi_win_decode.sv
module msi_win_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 20,
  parameter int SIZE_W   = 3,
  parameter int WORD_LOG = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFEE0_0000
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_i,
  output logic                hit_o,
  output logic                size_ok_o,
  output logic [ADDR_W-1:0]   full_addr_o
);
  localparam logic [SIZE_W-1:0] WORD_SZ = SIZE_W'(WORD_LOG);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [WIN_BITS-1:0] offset;

  assign offset      = addr_i[WIN_BITS-1:0];
  assign hit_o       = addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];
  assign size_ok_o   = size_i == WORD_SZ;
  // message address is rebuilt from base plus window offset
  assign full_addr_o = WIN_BASE + {{TAG_W{1'b0}}, offset};
endmodule

// File: rtl/msi_win_seq.sv
module msi_win_seq
  import msi_win_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  msi_msg_t              cap_msg_i,
  output logic                  busy_o,
  output logic                  xl_req_valid_o,
  input  logic                  xl_req_ready_i,
  output msi_msg_t              xl_req_msg_o,
  input  logic                  xl_rsp_valid_i,
  input  logic                  xl_rsp_err_i,
  input  msi_msg_t              xl_rsp_msg_i,
  output logic                  own_valid_o,
  input  logic                  dn_ready_i,
  output msi_msg_t              own_msg_o,
  output logic                  done_ok_o,
  output logic                  done_err_o
);
  seq_st_e  st_q, st_d;
  msi_msg_t msg_q, msg_d;

  always_comb begin
    st_d       = st_q;
    msg_d      = msg_q;
    done_ok_o  = 1'b0;
    done_err_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cap_i) begin
        st_d  = ST_XREQ;
        msg_d = cap_msg_i;
      end
      ST_XREQ: if (xl_req_ready_i) st_d = ST_XWAIT;
      ST_XWAIT: if (xl_rsp_valid_i) begin
        if (xl_rsp_err_i) begin
          st_d       = ST_IDLE;
          done_err_o = 1'b1;
        end else begin
          st_d  = ST_DNWR;
          msg_d = xl_rsp_msg_i;
        end
      end
      ST_DNWR: if (dn_ready_i) begin
        st_d      = ST_IDLE;
        done_ok_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      msg_q <= '0;
    end else begin
      st_q  <= st_d;
      msg_q <= msg_d;
    end
  end

  assign busy_o         = st_q != ST_IDLE;
  assign xl_req_valid_o = st_q == ST_XREQ;
  assign xl_req_msg_o   = msg_q;
  assign own_valid_o    = st_q == ST_DNWR;
  assign own_msg_o      = msg_q;

  assert_xreq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_req_valid_o && !xl_req_ready_i) |=> (xl_req_valid_o && $stable(xl_req_msg_o)));

  assert_dn_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_valid_o && !dn_ready_i) |=> (own_valid_o && $stable(own_msg_o)));

  assert_fault_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XWAIT && xl_rsp_valid_i && xl_rsp_err_i) |=> (!own_valid_o && !busy_o));
endmodule

// File: rtl/msi_win_rsp.sv
module msi_win_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ok_i,
  input  logic              err_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= ok_i | err_i;
      rsp_err_o   <= err_i;
    end
  end

  // reads in the window carry no data
  assign rsp_rdata_o = '0;
endmodule

// File: rtl/msi_window_intercept.sv
module msi_window_intercept
  import msi_win_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 20,
  parameter int SIZE_W   = 3,
  parameter int WORD_LOG = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFEE0_0000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  up_valid_i,
  output logic                  up_ready_o,
  input  logic                  up_write_i,
  input  logic [ADDR_W-1:0]     up_addr_i,
  input  logic [SIZE_W-1:0]     up_size_i,
  input  logic [MSG_DATA_W-1:0] up_wdata_i,
  output logic                  up_rsp_valid_o,
  output logic                  up_rsp_err_o,
  output logic [MSG_DATA_W-1:0] up_rsp_rdata_o,
  output logic                  xl_req_valid_o,
  input  logic                  xl_req_ready_i,
  output logic [MSG_ADDR_W-1:0] xl_req_addr_o,
  output logic [MSG_DATA_W-1:0] xl_req_data_o,
  input  logic                  xl_rsp_valid_i,
  input  logic                  xl_rsp_err_i,
  input  logic [MSG_ADDR_W-1:0] xl_rsp_addr_i,
  input  logic [MSG_DATA_W-1:0] xl_rsp_data_i,
  output logic                  dn_valid_o,
  input  logic                  dn_ready_i,
  output logic                  dn_write_o,
  output logic [MSG_ADDR_W-1:0] dn_addr_o,
  output logic [SIZE_W-1:0]     dn_size_o,
  output logic [MSG_DATA_W-1:0] dn_wdata_o
);
  localparam int PAD_W = MSG_ADDR_W - ADDR_W;
  localparam logic [SIZE_W-1:0] WORD_SZ = SIZE_W'(WORD_LOG);

  logic              hit, size_ok, busy, acc, cap, imm_ok, imm_err;
  logic              own_valid, done_ok, done_err;
  logic [ADDR_W-1:0] full_addr;
  msi_msg_t          cap_msg, xreq_msg, xrsp_msg, own_msg;

  msi_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SIZE_W(SIZE_W),
    .WORD_LOG(WORD_LOG), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr_i(up_addr_i), .size_i(up_size_i),
    .hit_o(hit), .size_ok_o(size_ok), .full_addr_o(full_addr)
  );

  assign up_ready_o = !busy && (hit || dn_ready_i);
  assign acc        = up_valid_i && up_ready_o && hit;
  assign cap        = acc && up_write_i && size_ok;
  assign imm_ok     = acc && !up_write_i && size_ok;
  assign imm_err    = acc && !size_ok;

  assign cap_msg.addr = {{PAD_W{1'b0}}, full_addr};
  assign cap_msg.data = up_wdata_i;
  assign xrsp_msg.addr = xl_rsp_addr_i;
  assign xrsp_msg.data = xl_rsp_data_i;

  msi_win_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_i(cap), .cap_msg_i(cap_msg), .busy_o(busy),
    .xl_req_valid_o(xl_req_valid_o), .xl_req_ready_i(xl_req_ready_i),
    .xl_req_msg_o(xreq_msg),
    .xl_rsp_valid_i(xl_rsp_valid_i), .xl_rsp_err_i(xl_rsp_err_i),
    .xl_rsp_msg_i(xrsp_msg),
    .own_valid_o(own_valid), .dn_ready_i(dn_ready_i), .own_msg_o(own_msg),
    .done_ok_o(done_ok), .done_err_o(done_err)
  );

  assign xl_req_addr_o = xreq_msg.addr;
  assign xl_req_data_o = xreq_msg.data;

  msi_win_rsp #(.DATA_W(MSG_DATA_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ok_i(imm_ok | done_ok), .err_i(imm_err | done_err),
    .rsp_valid_o(up_rsp_valid_o), .rsp_err_o(up_rsp_err_o),
    .rsp_rdata_o(up_rsp_rdata_o)
  );

  // busy: only the block's own write owns the downstream port
  always_comb begin
    if (busy) begin
      dn_valid_o = own_valid;
      dn_write_o = 1'b1;
      dn_addr_o  = own_msg.addr;
      dn_size_o  = WORD_SZ;
      dn_wdata_o = own_msg.data;
    end else begin
      dn_valid_o = up_valid_i && !hit;
      dn_write_o = up_write_i;
      dn_addr_o  = {{PAD_W{1'b0}}, up_addr_i};
      dn_size_o  = up_size_i;
      dn_wdata_o = up_wdata_i;
    end
  end

  assert_read_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_ok |=> (up_rsp_valid_o && !up_rsp_err_o && up_rsp_rdata_o == '0 && !xl_req_valid_o));

  assert_bad_size_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_err |=> (up_rsp_valid_o && up_rsp_err_o && !xl_req_valid_o));

  assert_cap_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (!up_ready_o && xl_req_valid_o && !dn_valid_o));

  assert_ok_after_dn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_valid && dn_ready_i) |=> (up_rsp_valid_o && !up_rsp_err_o && up_ready_o == (hit || dn_ready_i)));

  assert_fault_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_rsp_valid_i && xl_rsp_err_i && busy && !xl_req_valid_o && !own_valid)
      |=> (up_rsp_valid_o && up_rsp_err_o && !dn_valid_o));
endmodule

// File: tb/tb_msi_window_intercept.sv
module tb_msi_window_intercept;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        up_valid_i = 1'b0, up_write_i = 1'b0;
  logic [31:0] up_addr_i = '0, up_wdata_i = '0;
  logic [2:0]  up_size_i = '0;
  logic        up_ready_o, up_rsp_valid_o, up_rsp_err_o;
  logic [31:0] up_rsp_rdata_o;
  logic        xl_req_valid_o, xl_req_ready_i = 1'b0;
  logic [63:0] xl_req_addr_o;
  logic [31:0] xl_req_data_o;
  logic        xl_rsp_valid_i = 1'b0, xl_rsp_err_i = 1'b0;
  logic [63:0] xl_rsp_addr_i = '0;
  logic [31:0] xl_rsp_data_i = '0;
  logic        dn_valid_o, dn_ready_i = 1'b0, dn_write_o;
  logic [63:0] dn_addr_o;
  logic [2:0]  dn_size_o;
  logic [31:0] dn_wdata_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  msi_window_intercept dut (.*);

  function automatic bit in_win(logic [31:0] a);
    return a >= 32'hFEE0_0000 && a <= 32'hFEEF_FFFF;
  endfunction
  function automatic logic [63:0] exp_msg_addr(logic [31:0] a);
    return {32'h0, 32'hFEE0_0000 + (a & 32'h000F_FFFF)};
  endfunction
  // bench translator model
  function automatic bit xl_fault(logic [31:0] d);
    return d[31];
  endfunction
  function automatic logic [63:0] xl_addr(logic [31:0] d);
    return {32'h0000_0001, 20'hFEE00, d[7:0], 4'h0};
  endfunction
  function automatic logic [31:0] xl_data(logic [31:0] d);
    return {16'h0, d[15:0] ^ 16'h00A5};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pass_through(input logic wr, input logic [31:0] a,
                              input logic [2:0] sz, input logic [31:0] d, input logic rdy);
    @(negedge clk_i);
    up_valid_i = 1'b1; up_write_i = wr; up_addr_i = a; up_size_i = sz; up_wdata_i = d;
    dn_ready_i = rdy;
    #1;
    chk(dn_valid_o == 1'b1, "R1", "dn_valid", 64'(dn_valid_o), 64'd1);
    chk(dn_addr_o == {32'h0, a}, "R1", "dn_addr", dn_addr_o, {32'h0, a});
    chk(dn_write_o == wr && dn_size_o == sz && dn_wdata_o == d, "R1", "dn_fields",
        {dn_write_o, dn_size_o, dn_wdata_o}, {wr, sz, d});
    chk(up_ready_o == rdy, "R1", "ready_coupling", 64'(up_ready_o), 64'(rdy));
    chk(xl_req_valid_o == 1'b0, "R1", "no_xl_req", 64'(xl_req_valid_o), 64'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    up_valid_i = 1'b0; dn_ready_i = 1'b0;
    #1;
    chk(up_rsp_valid_o == 1'b0, "R1", "no_rsp", 64'(up_rsp_valid_o), 64'd0);
  endtask

  // window access answered at once: read of size 2, or any size other than 2
  task automatic win_imm(input logic wr, input logic [31:0] a, input logic [2:0] sz);
    bit bad = (sz != 3'd2);
    @(negedge clk_i);
    up_valid_i = 1'b1; up_write_i = wr; up_addr_i = a; up_size_i = sz; up_wdata_i = $urandom;
    dn_ready_i = $urandom_range(0, 1);
    #1;
    chk(up_ready_o == 1'b1 && dn_valid_o == 1'b0, bad ? "R3" : "R2", "claim",
        {up_ready_o, dn_valid_o}, 64'b10);
    @(posedge clk_i);
    @(negedge clk_i);
    up_valid_i = 1'b0; dn_ready_i = 1'b0;
    #1;
    if (bad) begin
      chk(up_rsp_valid_o && up_rsp_err_o, "R3", "err_rsp", {up_rsp_valid_o, up_rsp_err_o}, 64'b11);
      chk(!xl_req_valid_o, "R3", "no_xl_req", 64'(xl_req_valid_o), 64'd0);
    end else begin
      chk(up_rsp_valid_o && !up_rsp_err_o, "R2", "ok_rsp", {up_rsp_valid_o, up_rsp_err_o}, 64'b10);
      chk(up_rsp_rdata_o == 32'h0, "R2", "rdata", 64'(up_rsp_rdata_o), 64'd0);
      chk(!xl_req_valid_o && !dn_valid_o, "R2", "no_side_effect",
          {xl_req_valid_o, dn_valid_o}, 64'b00);
    end
    @(negedge clk_i);
    #1;
    chk(!up_rsp_valid_o, bad ? "R3" : "R2", "rsp_single", 64'(up_rsp_valid_o), 64'd0);
  endtask

  task automatic win_write(input logic [31:0] a, input logic [31:0] d, input bit probe);
    bit f = xl_fault(d);
    @(negedge clk_i);
    up_valid_i = 1'b1; up_write_i = 1'b1; up_addr_i = a; up_size_i = 3'd2; up_wdata_i = d;
    #1;
    chk(up_ready_o == 1'b1, "R4", "accept", 64'(up_ready_o), 64'd1);
    @(posedge clk_i);
    @(negedge clk_i);
    up_valid_i = 1'b0;
    #1;
    chk(xl_req_valid_o == 1'b1, "R4", "xl_valid", 64'(xl_req_valid_o), 64'd1);
    chk(xl_req_addr_o == exp_msg_addr(a), "R4", "xl_addr", xl_req_addr_o, exp_msg_addr(a));
    chk(xl_req_data_o == d, "R4", "xl_data", 64'(xl_req_data_o), 64'(d));
    if (probe) begin
      up_valid_i = 1'b1; up_write_i = 1'b1; up_addr_i = 32'h1000_0040; dn_ready_i = 1'b1;
      #1;
      chk(!up_ready_o && !dn_valid_o, "R7", "blocked", {up_ready_o, dn_valid_o}, 64'b00);
    end
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk_i);
      #1;
      chk(xl_req_valid_o && xl_req_data_o == d, "R4", "xl_hold", 64'(xl_req_data_o), 64'(d));
      if (probe) chk(!up_ready_o && !dn_valid_o, "R7", "blocked", {up_ready_o, dn_valid_o}, 64'b00);
    end
    @(negedge clk_i);
    xl_req_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    xl_req_ready_i = 1'b0;
    #1;
    chk(!xl_req_valid_o, "R4", "xl_drop", 64'(xl_req_valid_o), 64'd0);
    if (probe) begin
      chk(!up_ready_o && !dn_valid_o, "R7", "blocked_wait", {up_ready_o, dn_valid_o}, 64'b00);
      up_valid_i = 1'b0; dn_ready_i = 1'b0;
    end
    idle_wait($urandom_range(0, 2));
    @(negedge clk_i);
    xl_rsp_valid_i = 1'b1; xl_rsp_err_i = f; xl_rsp_addr_i = xl_addr(d); xl_rsp_data_i = xl_data(d);
    @(posedge clk_i);
    @(negedge clk_i);
    xl_rsp_valid_i = 1'b0; xl_rsp_addr_i = '0; xl_rsp_data_i = '0;
    #1;
    if (f) begin
      chk(up_rsp_valid_o && up_rsp_err_o, "R5", "err_rsp", {up_rsp_valid_o, up_rsp_err_o}, 64'b11);
      chk(!dn_valid_o, "R5", "dropped", 64'(dn_valid_o), 64'd0);
      @(negedge clk_i);
      #1;
      chk(!dn_valid_o && !up_rsp_valid_o, "R5", "still_dropped", {dn_valid_o, up_rsp_valid_o}, 64'b00);
    end else begin
      chk(dn_valid_o && dn_write_o && dn_size_o == 3'd2, "R6", "dn_req",
          {dn_valid_o, dn_write_o, dn_size_o}, {2'b11, 3'd2});
      chk(dn_addr_o == xl_addr(d), "R6", "dn_addr", dn_addr_o, xl_addr(d));
      chk(dn_wdata_o == xl_data(d), "R6", "dn_data", 64'(dn_wdata_o), 64'(xl_data(d)));
      chk(!up_rsp_valid_o && !up_ready_o, "R7", "busy_dn", {up_rsp_valid_o, up_ready_o}, 64'b00);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk_i);
        #1;
        chk(dn_valid_o && dn_addr_o == xl_addr(d), "R6", "dn_hold", dn_addr_o, xl_addr(d));
      end
      @(negedge clk_i);
      dn_ready_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      dn_ready_i = 1'b0;
      #1;
      chk(up_rsp_valid_o && !up_rsp_err_o, "R6", "ok_rsp", {up_rsp_valid_o, up_rsp_err_o}, 64'b10);
      chk(!dn_valid_o, "R6", "dn_done", 64'(dn_valid_o), 64'd0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    #1;
    chk(!up_rsp_valid_o && !xl_req_valid_o && !dn_valid_o, "R8", "in_reset",
        {up_rsp_valid_o, xl_req_valid_o, dn_valid_o}, 64'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(!up_rsp_valid_o && !xl_req_valid_o && !dn_valid_o, "R8", "after_reset",
        {up_rsp_valid_o, xl_req_valid_o, dn_valid_o}, 64'b000);

    // window edges
    pass_through(1'b1, 32'hFEDF_FFFC, 3'd2, 32'hAAAA_5555, 1'b1);
    pass_through(1'b0, 32'hFEF0_0000, 3'd2, 32'h0, 1'b0);
    pass_through(1'b1, 32'h0000_1000, 3'd0, 32'h12, 1'b1);
    win_write(32'hFEE0_0000, 32'h0000_1234, 1'b1);
    win_write(32'hFEEF_FFFC, 32'h8000_00FF, 1'b1);
    win_write(32'hFEE0_1000, 32'h0000_4041, 1'b0);
    win_imm(1'b0, 32'hFEEF_FFFF, 3'd2);
    win_imm(1'b0, 32'hFEE0_0000, 3'd2);
    win_imm(1'b1, 32'hFEE0_0004, 3'd0);
    win_imm(1'b1, 32'hFEE0_0008, 3'd1);
    win_imm(1'b1, 32'hFEE0_0010, 3'd3);
    win_imm(1'b0, 32'hFEEF_FFF0, 3'd1);

    for (int i = 0; i < 120; i++) begin
      int kind = $urandom_range(0, 3);
      logic [31:0] a;
      case ($urandom_range(0, 2))
        0: a = 32'hFEE0_0000 | ($urandom & 32'h000F_FFFC);
        1: a = 32'hFED0_0000 | ($urandom & 32'h001F_FFFC);
        default: a = $urandom;
      endcase
      if (!in_win(a)) pass_through(kind[0], a, 3'($urandom_range(0, 3)), $urandom, kind[1]);
      else if (kind == 0) win_imm(1'b0, a, 3'd2);
      else if (kind == 1) win_imm($urandom_range(0, 1), a, 3'($urandom_range(0, 1)));
      else win_write(a, $urandom, kind == 3);
    end

    idle_wait(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule